// File: doc/BRIEF.md
# Serial Video Word Aligner

This block sits behind the line decoder of a serial digital video receiver. It takes one decoded bit per bit-enable cycle and packs the bits into 10-bit parallel words. It raises a one-cycle word strobe each time a word is complete, which gives the parallel-rate enable. A divide-by-ten counter marks the word boundaries. That counter runs freely until a timing reference preamble appears in the bit stream. The preamble is ten or more ones followed by twenty zeros, which is the word sequence 3FF, 000, 000 on the wire. When it is seen, the counter restarts so that the bits that follow line up with the preamble.

The word that follows a preamble is the identification word. If its header bit is set, bit 6 of that word sets or clears a line-timing flag. A start-of-active-video word clears the flag and an end-of-active-video word sets it. When the stream is not scrambled video, a bypass input freezes the flag, because its value would carry no meaning.

Top module: `sdi_word_aligner`

## Requirements
- R1: While rst_ni is low, word_o is 0, word_vld_o is 0 and h_o is 0.
- R2: Bits are received least significant first: the first bit accepted for a word ends up in word_o[0] and the tenth in word_o[9].
- R3: word_vld_o is high for exactly one clock, in the cycle after the bit enable that carries the tenth bit of a word. word_o takes the new word in that same cycle and keeps its value at all other times.
- R4: When bit_en_i is low, the value of bit_i has no effect on any word.
- R5: A preamble is a run of at least 10 consecutive one bits followed by 20 consecutive zero bits. On the 20th zero the word counter restarts, so the next 10 accepted bits form the identification word.
- R6: If a preamble falls across the word boundaries, every word completed before the 20th zero is output unchanged. The bits already gathered toward the incomplete word are dropped, and no strobe is given for them.
- R7: An identification word whose bit 9 is 1 is a valid header. In the cycle after its strobe, h_o takes the value of bit 6: 0 for start of active video, 1 for end of active video.
- R8: An identification word with bit 9 equal to 0 leaves h_o unchanged. Words that do not follow a preamble never change h_o.
- R9: While bypass_i is high, h_o holds its value even after a valid identification word.
- R10: A run of only 9 ones before 20 zeros is not a preamble: the word that follows is not treated as an identification word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies bit_i for this cycle |
| bit_i | input | 1 | Decoded serial data bit |
| bypass_i | input | 1 | High freezes the line-timing flag |
| word_o | output | 10 | Assembled parallel word |
| word_vld_o | output | 1 | One-cycle strobe, high when word_o is new |
| h_o | output | 1 | Line-timing flag: 0 after start, 1 after end of active video |

## Verification
Some properties are checked by the assertions on every cycle. The strobe is always a single-cycle pulse, and the word holds between strobes. The flag changes only in the cycle after a strobe, only when bypass was low, only to the strobed word's bit 6, and only when that word's bit 9 was set. Other behaviour only the bench scenarios can show. These are whether a flag change really belongs to a word that followed a preamble, that a preamble straddling word boundaries drops the partial word and realigns the ones after it, and that a nine-ones run is passed over. The bench checks these against streams whose word boundaries it has worked out by hand.

// File: rtl/sdi_align_pkg.sv
package sdi_align_pkg;
  localparam int unsigned WORD_W_DEF    = 10;
  localparam int unsigned ONES_LEN_DEF  = 10;
  localparam int unsigned ZEROS_LEN_DEF = 20;
  localparam int unsigned HDR_BIT_DEF   = 9;  // set on a valid identification word
  localparam int unsigned KIND_BIT_DEF  = 6;  // 1 = end, 0 = start of active video
endpackage

// File: rtl/trs_seeker.sv
module trs_seeker #(
  parameter int unsigned ONES_LEN  = 10,
  parameter int unsigned ZEROS_LEN = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int unsigned OW = $clog2(ONES_LEN + 1);
  localparam int unsigned ZW = $clog2(ZEROS_LEN + 1);

  logic [OW-1:0] ones_q;
  logic [ZW-1:0] zeros_q;
  logic          armed_q;

  assign hit_o = bit_en_i && !bit_i && armed_q && (zeros_q == ZW'(ZEROS_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q  <= '0;
      zeros_q <= '0;
      armed_q <= 1'b0;
    end else if (bit_en_i) begin
      if (bit_i) begin
        // saturating run of ones
        if (ones_q != OW'(ONES_LEN)) ones_q <= ones_q + OW'(1);
        zeros_q <= '0;
        armed_q <= 1'b0;
      end else begin
        ones_q <= '0;
        if (hit_o) begin
          armed_q <= 1'b0;
          zeros_q <= '0;
        end else if (ones_q == OW'(ONES_LEN)) begin
          armed_q <= 1'b1;
          zeros_q <= ZW'(1);
        end else if (armed_q) begin
          zeros_q <= zeros_q + ZW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/word_deser.sv
module word_deser #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              hit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o,
  output logic              id_o
);
  localparam int unsigned CW = $clog2(WORD_W);

  logic [CW-1:0]     cnt_q;
  logic [WORD_W-2:0] sr_q;
  logic              id_pend_q;
  logic              last;

  assign last = (cnt_q == CW'(WORD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sr_q      <= '0;
      id_pend_q <= 1'b0;
      word_o    <= '0;
      vld_o     <= 1'b0;
      id_o      <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      id_o  <= 1'b0;
      if (bit_en_i) begin
        if (WORD_W > 2) sr_q <= {bit_i, sr_q[WORD_W-2:1]};
        else            sr_q <= bit_i;
        if (last) begin
          word_o    <= {bit_i, sr_q};
          vld_o     <= 1'b1;
          id_o      <= id_pend_q;
          id_pend_q <= 1'b0;
        end
        if (hit_i) begin
          // realign: next bit starts the identification word
          cnt_q     <= '0;
          id_pend_q <= 1'b1;
        end else begin
          cnt_q <= last ? '0 : cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/line_flag.sv
module line_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic id_vld_i,
  input  logic hdr_bit_i,
  input  logic kind_bit_i,
  input  logic bypass_i,
  output logic h_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               h_o <= 1'b0;
    else if (id_vld_i && hdr_bit_i && !bypass_i) h_o <= kind_bit_i;
  end
endmodule

// File: rtl/sdi_word_aligner.sv
module sdi_word_aligner
  import sdi_align_pkg::*;
#(
  parameter int unsigned WORD_W    = WORD_W_DEF,
  parameter int unsigned ONES_LEN  = ONES_LEN_DEF,
  parameter int unsigned ZEROS_LEN = ZEROS_LEN_DEF,
  parameter int unsigned HDR_BIT   = HDR_BIT_DEF,
  parameter int unsigned KIND_BIT  = KIND_BIT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              bypass_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              h_o
);
  logic hit;
  logic id_vld;

  trs_seeker #(.ONES_LEN(ONES_LEN), .ZEROS_LEN(ZEROS_LEN)) u_seek (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_en_i(bit_en_i),
    .bit_i   (bit_i),
    .hit_o   (hit)
  );

  word_deser #(.WORD_W(WORD_W)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_en_i(bit_en_i),
    .bit_i   (bit_i),
    .hit_i   (hit),
    .word_o  (word_o),
    .vld_o   (word_vld_o),
    .id_o    (id_vld)
  );

  line_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_vld_i  (id_vld),
    .hdr_bit_i (word_o[HDR_BIT]),
    .kind_bit_i(word_o[KIND_BIT]),
    .bypass_i  (bypass_i),
    .h_o       (h_o)
  );
endmodule

// File: rtl/sdi_word_aligner_chk.sv
module sdi_word_aligner_chk #(
  parameter int unsigned WORD_W   = 10,
  parameter int unsigned HDR_BIT  = 9,
  parameter int unsigned KIND_BIT = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_en_i,
  input logic              bypass_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o,
  input logic              h_o
);
  p_strobe_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  p_word_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> $stable(word_o));

  p_strobe_needs_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(bit_en_i));

  p_h_after_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(h_o) |-> ($past(word_vld_o) && $past(word_o[HDR_BIT])));

  p_h_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(h_o) |-> (h_o == $past(word_o[KIND_BIT])));

  p_h_bypass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(h_o) |-> !$past(bypass_i));
endmodule

bind sdi_word_aligner sdi_word_aligner_chk #(
  .WORD_W(WORD_W), .HDR_BIT(HDR_BIT), .KIND_BIT(KIND_BIT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_en_i  (bit_en_i),
  .bypass_i  (bypass_i),
  .word_o    (word_o),
  .word_vld_o(word_vld_o),
  .h_o       (h_o)
);

// File: tb/sdi_word_aligner_tb_top.sv
`timescale 1ns/1ps
module sdi_word_aligner_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_v = 1'b0;
  logic       bypass = 1'b0;
  logic [9:0] word;
  logic       word_vld;
  logic       h;

  int checks = 0;
  int fails  = 0;
  logic [9:0] exp_q[$];

  always #2 clk = ~clk;

  sdi_word_aligner dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_v),
    .bypass_i(bypass), .word_o(word), .word_vld_o(word_vld), .h_o(h)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic send_bit(input logic b, input bit gap);
    @(negedge clk); bit_en = 1'b1; bit_v = b;
    if (gap) begin
      @(negedge clk); bit_en = 1'b0; bit_v = ~b;  // R4 noise while disabled
    end
  endtask

  task automatic send_word(input logic [9:0] w, input bit gap = 1'b0);
    exp_q.push_back(w);
    for (int i = 0; i < 10; i++) send_bit(w[i], gap);
  endtask

  task automatic send_raw(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_en = 1'b0; bit_v = 1'b1;
    end
  endtask

  task automatic preamble();
    send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
  endtask

  task automatic chk_h(input logic exp, input string req);
    idle(3);
    chk(h === exp, req, h, exp);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && word_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected strobe", word, 0);
      else begin
        automatic logic [9:0] e = exp_q.pop_front();
        chk(word === e, "R2 R3 R6 word", word, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(word === 10'h000, "R1 word", word, 0);
    chk(word_vld === 1'b0, "R1 strobe", word_vld, 0);
    chk(h === 1'b0, "R1 h", h, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R4: plain words, some with disabled cycles carrying noise
    send_word(10'h155);
    send_word(10'h2A3, 1'b1);
    send_word(10'h3C1);

    // R5 R7: aligned preamble, end of active video
    preamble(); send_word(10'h274);
    chk_h(1'b1, "R7 eav sets h");
    send_word(10'h0AA);

    // R7: start of active video
    preamble(); send_word(10'h200);
    chk_h(1'b0, "R7 sav clears h");

    // R6: preamble offset by 3 bits; in-flight words 3FD, 007, 000; 3 bits dropped
    exp_q.push_back(10'h3FD); exp_q.push_back(10'h007); exp_q.push_back(10'h000);
    send_raw(1'b1, 1); send_raw(1'b0, 1); send_raw(1'b1, 1);
    send_raw(1'b1, 10); send_raw(1'b0, 20);
    send_word(10'h274);
    chk_h(1'b1, "R5 R6 realigned eav sets h");
    send_word(10'h123);

    preamble(); send_word(10'h200);
    chk_h(1'b0, "R7 sav clears h again");

    // R8: data word with bit9/bit6 set does not touch h
    send_word(10'h2C0);
    chk_h(1'b0, "R8 data word leaves h");

    // R8: id word without header bit
    preamble(); send_word(10'h040);
    chk_h(1'b0, "R8 invalid id leaves h");

    // R9: bypass freezes h
    bypass = 1'b1;
    preamble(); send_word(10'h274);
    chk_h(1'b0, "R9 bypass holds h");
    bypass = 1'b0;

    // R10: only 9 ones before the zeros
    send_word(10'h000);
    send_word(10'h1FF); send_word(10'h000); send_word(10'h000); send_word(10'h274);
    chk_h(1'b0, "R10 short run ignored");

    idle(4);
    chk(exp_q.size() == 0, "R3 all words strobed", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule